// File: doc/BRIEF.md
# Paired-Register 16-Byte Store Sequencer

This block performs one 16-byte store whose source is an even/odd pair of 64-bit registers. A command carries the base register value, a flag telling that the base register field named register 0, a 14-bit scaled displacement, the endian mode and the two register values. The block forms the effective address and arranges the two doublewords for the selected byte order. It then drives two 64-bit write requests to memory over a valid/ready channel, the lower address first, and finishes with a one-cycle completion pulse.

The effective address is the base plus the displacement, sign-extended, with two zero bits appended. When the base field is register 0, the base counts as zero. In big-endian mode the even register is written at the effective address and the odd register eight bytes above it. In little-endian mode each register is byte-reversed, and the two take the opposite addresses. The block changes no status of any kind. It accepts no new command until the current pair of writes has completed.

Top module: `qstore_seq`

## Requirements
- R1: The effective address EA equals the base plus the 14-bit displacement field, sign-extended from its bit 13 after two zero bits are appended below it. The sum is taken modulo 2^64.
- R2: When cmd_ra_zero is 1, cmd_base has no effect and EA is the extended displacement alone.
- R3: In big-endian mode (cmd_le = 0), the first write carries cmd_even and the second write carries cmd_odd, each unchanged.
- R4: In little-endian mode (cmd_le = 1), the first write carries cmd_odd with its eight bytes in reverse order, and the second write carries cmd_even with its eight bytes in reverse order. Bits [7:0] swap with [63:56], and so on.
- R5: The first write goes to EA and the second to EA+8, always in that order.
- R6: Each write request stays valid, with unchanged address and data, until wr_ready is seen high at a clock edge.
- R7: cmd_ready is high only while idle. A cmd_valid offered while a sequence is in progress is not taken and does not alter the writes in flight.
- R8: done is high for exactly one cycle, the cycle after the second write is accepted. At that point wr_valid is low and cmd_ready is high.
- R9: While rst_n is low, at any time, wr_valid and done are low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_base | input | 64 | Base register value |
| cmd_ra_zero | input | 1 | Base field names register 0; base treated as zero |
| cmd_disp | input | 14 | Scaled displacement field |
| cmd_le | input | 1 | 1 = little-endian mode |
| cmd_even | input | 64 | Even register of the pair |
| cmd_odd | input | 64 | Odd register of the pair |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 64 | Byte address of the write |
| wr_data | output | 64 | Doubleword to be written |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a command offered while a sequence is still in progress. If it leaked through, it would corrupt the pending second doubleword. The stimulus therefore keeps cmd_valid high with different operands through the first write and through its stall cycles, then checks that both writes still carry the original address and data. The sweep also crosses the displacement extremes (most negative, most positive, zero, minus one) with both endian modes, both base modes and stall lengths of zero to two cycles. It also asserts reset in the middle of a sequence.

// File: rtl/qst_pkg.sv
`timescale 1ns/1ps
package qst_pkg;
   typedef enum logic [1:0] {
      QS_IDLE = 2'd0,
      QS_LO   = 2'd1,
      QS_HI   = 2'd2
   } qs_state_t;
endpackage

// File: rtl/qst_addr.sv
`timescale 1ns/1ps
// Effective address: optional base plus scaled, sign-extended displacement.
module qst_addr #(
   parameter int ADDR_W  = 64,
   parameter int DISP_W  = 14,
   parameter int SCALE_B = 2
) (
   input  logic [ADDR_W-1:0] base,
   input  logic              base_zero,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] ea
);
   localparam int EXT_W = ADDR_W - DISP_W - SCALE_B;

   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] base_eff;

   generate
      if (EXT_W < 1) begin : g_bad_width
         $error("qst_addr: displacement plus scale must be narrower than the address");
      end else begin : g_ext
         assign offset = {{EXT_W{disp[DISP_W-1]}}, disp, {SCALE_B{1'b0}}};
      end
   endgenerate

   assign base_eff = base_zero ? '0 : base;
   assign ea       = base_eff + offset;
endmodule

// File: rtl/qst_swap.sv
`timescale 1ns/1ps
// Byte-order reversal of one word, selected by a control input.
module qst_swap #(
   parameter int DATA_W = 64
) (
   input  logic              rev,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int NBYTES = DATA_W / 8;

   logic [DATA_W-1:0] flipped;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("qst_swap: data width must be a whole number of bytes");
      end
      for (genvar i = 0; i < NBYTES; i++) begin : g_byte
         assign flipped[8*i +: 8] = din[8*(NBYTES-1-i) +: 8];
      end
   endgenerate

   assign dout = rev ? flipped : din;
endmodule

// File: rtl/qst_pack.sv
`timescale 1ns/1ps
// Arranges the register pair into low/high address doublewords per endian mode.
module qst_pack #(
   parameter int DATA_W = 64
) (
   input  logic              le_mode,
   input  logic [DATA_W-1:0] even_reg,
   input  logic [DATA_W-1:0] odd_reg,
   output logic [DATA_W-1:0] lo_word,
   output logic [DATA_W-1:0] hi_word
);
   logic [DATA_W-1:0] lo_src;
   logic [DATA_W-1:0] hi_src;

   // Little-endian swaps which register lands at the lower address.
   assign lo_src = le_mode ? odd_reg  : even_reg;
   assign hi_src = le_mode ? even_reg : odd_reg;

   qst_swap #(.DATA_W(DATA_W)) u_swap_lo (
      .rev  (le_mode),
      .din  (lo_src),
      .dout (lo_word)
   );

   qst_swap #(.DATA_W(DATA_W)) u_swap_hi (
      .rev  (le_mode),
      .din  (hi_src),
      .dout (hi_word)
   );
endmodule

// File: rtl/qst_ctrl.sv
`timescale 1ns/1ps
// Two-beat write sequencer with completion pulse.
module qst_ctrl
   import qst_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] ea_in,
   input  logic [DATA_W-1:0] lo_in,
   input  logic [DATA_W-1:0] hi_in,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              done
);
   localparam int STEP = DATA_W / 8;

   qs_state_t         state_q;
   logic [ADDR_W-1:0] ea_q;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] hi_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= QS_IDLE;
         ea_q    <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            QS_IDLE: if (cmd_valid) begin
               ea_q    <= ea_in;
               lo_q    <= lo_in;
               hi_q    <= hi_in;
               state_q <= QS_LO;
            end
            QS_LO: if (wr_ready) state_q <= QS_HI;
            QS_HI: if (wr_ready) begin
               state_q <= QS_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= QS_IDLE;
         endcase
      end
   end

   assign cmd_ready = (state_q == QS_IDLE);
   assign wr_valid  = (state_q == QS_LO) || (state_q == QS_HI);
   assign wr_addr   = (state_q == QS_HI) ? ea_q + ADDR_W'(STEP) : ea_q;
   assign wr_data   = (state_q == QS_HI) ? hi_q : lo_q;
   assign done      = done_q;

   // R6: a stalled request holds address and data.
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

   // R5: the beat after an accepted one is eight bytes higher.
   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_valid && wr_ready) && wr_valid |-> wr_addr == $past(wr_addr) + ADDR_W'(STEP));

   // R7: no command taken while writes are outstanding.
   p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !cmd_ready);

   // R8: completion follows an accepted write and lasts one cycle.
   p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wr_valid && wr_ready) && !wr_valid);
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/qstore_seq.sv
`timescale 1ns/1ps
module qstore_seq #(
   parameter int ADDR_W = 64,
   parameter int DATA_W = 64,
   parameter int DISP_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_base,
   input  logic              cmd_ra_zero,
   input  logic [DISP_W-1:0] cmd_disp,
   input  logic              cmd_le,
   input  logic [DATA_W-1:0] cmd_even,
   input  logic [DATA_W-1:0] cmd_odd,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              done
);
   localparam int SCALE_B = 2;

   logic [ADDR_W-1:0] ea;
   logic [DATA_W-1:0] lo_word;
   logic [DATA_W-1:0] hi_word;

   qst_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SCALE_B(SCALE_B)) u_addr (
      .base      (cmd_base),
      .base_zero (cmd_ra_zero),
      .disp      (cmd_disp),
      .ea        (ea)
   );

   qst_pack #(.DATA_W(DATA_W)) u_pack (
      .le_mode  (cmd_le),
      .even_reg (cmd_even),
      .odd_reg  (cmd_odd),
      .lo_word  (lo_word),
      .hi_word  (hi_word)
   );

   qst_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .ea_in     (ea),
      .lo_in     (lo_word),
      .hi_in     (hi_word),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .done      (done)
   );
endmodule

// File: tb/qstore_seq_test.sv
`timescale 1ns/1ps
module qstore_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [63:0] cmd_base = '0;
   logic        cmd_ra_zero = 1'b0;
   logic [13:0] cmd_disp = '0;
   logic        cmd_le = 1'b0;
   logic [63:0] cmd_even = '0;
   logic [63:0] cmd_odd = '0;
   logic        wr_valid;
   logic        wr_ready = 1'b0;
   logic [63:0] wr_addr;
   logic [63:0] wr_data;
   logic        done;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #2.5 clk = ~clk;

   qstore_seq uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_base(cmd_base), .cmd_ra_zero(cmd_ra_zero), .cmd_disp(cmd_disp),
      .cmd_le(cmd_le), .cmd_even(cmd_even), .cmd_odd(cmd_odd),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data), .done(done)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] rev8(input logic [63:0] x);
      logic [63:0] r;
      for (int i = 0; i < 8; i++) r[8*i +: 8] = x[56-8*i +: 8];
      return r;
   endfunction

   task automatic run_seq(input logic [63:0] base, input logic rz, input logic [13:0] d,
                          input logic le, input logic [63:0] ev, input logic [63:0] od,
                          input int st1, input int st2);
      logic [63:0] ea, lo, hi, off;
      off = {{48{d[13]}}, d, 2'b00};
      ea  = (rz ? 64'd0 : base) + off;
      lo  = le ? rev8(od) : ev;
      hi  = le ? rev8(ev) : od;
      @(negedge clk);
      chk("R7 idle ready", {63'd0, cmd_ready}, 64'd1);
      cmd_valid = 1'b1; cmd_base = base; cmd_ra_zero = rz; cmd_disp = d;
      cmd_le = le; cmd_even = ev; cmd_odd = od;
      @(negedge clk);
      // offer a conflicting command while busy (R7)
      cmd_base = ~base; cmd_ra_zero = ~rz; cmd_disp = ~d; cmd_le = ~le;
      cmd_even = ~ev ^ 64'h1234; cmd_odd = od + 64'd77;
      chk("R7 busy not ready", {63'd0, cmd_ready}, 64'd0);
      chk("R5 first valid", {63'd0, wr_valid}, 64'd1);
      chk("R1 R2 R5 first addr", wr_addr, ea);
      chk(le ? "R4 first data" : "R3 first data", wr_data, lo);
      for (int k = 0; k < st1; k++) begin
         @(negedge clk);
         chk("R6 hold addr lo", wr_addr, ea);
         chk("R6 hold data lo", wr_data, lo);
         chk("R6 hold valid lo", {63'd0, wr_valid}, 64'd1);
      end
      wr_ready = 1'b1;
      @(negedge clk);
      wr_ready = 1'b0;
      chk("R5 second addr", wr_addr, ea + 64'd8);
      chk(le ? "R4 second data" : "R3 second data", wr_data, hi);
      chk("R8 no early done", {63'd0, done}, 64'd0);
      chk("R7 still busy", {63'd0, cmd_ready}, 64'd0);
      for (int k = 0; k < st2; k++) begin
         @(negedge clk);
         chk("R6 hold addr hi", wr_addr, ea + 64'd8);
         chk("R6 hold data hi", wr_data, hi);
      end
      wr_ready = 1'b1;
      cmd_valid = 1'b0;
      @(negedge clk);
      wr_ready = 1'b0;
      chk("R8 done pulse", {63'd0, done}, 64'd1);
      chk("R8 valid low at done", {63'd0, wr_valid}, 64'd0);
      chk("R8 ready at done", {63'd0, cmd_ready}, 64'd1);
      @(negedge clk);
      chk("R8 done single cycle", {63'd0, done}, 64'd0);
   endtask

   initial begin
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [13:0] disps [4];
      logic [63:0] bases [2];
      int idx;
      disps[0] = 14'h2000; disps[1] = 14'h1FFF; disps[2] = 14'h0000; disps[3] = 14'h3FFF;
      bases[0] = 64'h0000_0000_0001_0000; bases[1] = 64'hFFFF_FFFF_FFFF_FFF8;
      #1;
      chk("R9 reset valid", {63'd0, wr_valid}, 64'd0);
      chk("R9 reset done", {63'd0, done}, 64'd0);
      chk("R9 reset ready", {63'd0, cmd_ready}, 64'd1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idx = 0;
      for (int di = 0; di < 4; di++)
         for (int bi = 0; bi < 2; bi++)
            for (int rz = 0; rz < 2; rz++)
               for (int le = 0; le < 2; le++) begin
                  run_seq(bases[bi] + 64'(idx * 16), rz[0], disps[di], le[0],
                          64'h0011_2233_4455_6677 + 64'(idx),
                          64'h8899_AABB_CCDD_EEFF ^ 64'(idx << 8),
                          idx % 3, (idx + 1) % 3);
                  idx++;
               end
      // reset in the middle of a sequence (R9)
      @(negedge clk);
      cmd_valid = 1'b1; cmd_base = 64'h100; cmd_ra_zero = 1'b0; cmd_disp = 14'h4;
      cmd_le = 1'b0; cmd_even = 64'hA; cmd_odd = 64'hB;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9 pre-reset busy", {63'd0, wr_valid}, 64'd1);
      #1 rst_n = 1'b0;
      #0.5;
      chk("R9 mid reset valid", {63'd0, wr_valid}, 64'd0);
      chk("R9 mid reset ready", {63'd0, cmd_ready}, 64'd1);
      chk("R9 mid reset done", {63'd0, done}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 idle after reset", {63'd0, wr_valid}, 64'd0);
      run_seq(64'h0000_0000_0000_1000, 1'b0, 14'h0010, 1'b1,
              64'h0102_0304_0506_0708, 64'h1112_1314_1516_1718, 0, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule